// File: doc/BRIEF.md
# CPU exception entry sequencer

This block carries a 32-bit processor core from normal execution into an exception handler. After the active-low reset input is released it fetches the starting program counter and stack pointer from two fixed word addresses. It then clears the vector base and raises the interrupt mask to its highest level. For any other exception it saves the status word and the return address on the stack below R15, and then reads the handler address from a vector table at the vector base.

The core presents its pending sources as level flags: address error, interrupt with priority level and vector number, trap with an 8-bit immediate, and an undefined-opcode flag qualified by a delay-slot flag and a delay-slot PC-write flag. The core also supplies its current PC, SR, R15 and VBR. The block runs every access through a single word-wide memory port with a ready handshake. It reports the results as one-cycle write strobes, each with a value, for PC, R15, the interrupt mask and a VBR clear.

Top module: `exc_entry_seq`

## Requirements
- R1: While rst_ni is low, mem_req_o stays 0. After rst_ni rises the block reads address 0x00000000 and then address 0x00000004 (mem_we_o = 0 for both).
- R2: In the cycle after the handshake of the second reset read, pc_wr_o, r15_wr_o, vbr_clr_o and imask_wr_o all pulse together. pc_o carries the word read from 0x0, r15_o carries the word read from 0x4, and imask_o is 4'b1111.
- R3: A non-reset exception first writes sr_i (as sampled at acceptance) to R15−4 and then pc_i to R15−8. In the cycle after the second write completes, r15_wr_o pulses with R15−8 on r15_o.
- R4: After the pushes the block reads VBR + 4 × vector number. In the cycle after that read completes, pc_wr_o pulses and pc_o carries the word read.
- R5: The vector numbers are: 4 for general illegal, 6 for illegal slot, 9 for address error, trap_imm_i for a trap, and irq_vec_i for an interrupt.
- R6: Only an interrupt makes imask_wr_o pulse, together with pc_wr_o, with imask_o equal to the accepted irq_lvl_i. Other non-reset exceptions leave imask_wr_o at 0.
- R7: An address error or an interrupt is accepted only in a cycle where instr_done_i is 1. Without instr_done_i these sources start no memory access.
- R8: When several eligible sources are present in the same cycle, the order of precedence is: address error, then interrupt, then illegal slot, then general illegal, then trap.
- R9: Illegal slot means in_slot_i & (undef_i | slot_pc_wr_i). General illegal means undef_i & ~in_slot_i. slot_pc_wr_i without in_slot_i raises nothing.
- R10: A memory request that is not ready keeps mem_req_o, mem_addr_o, mem_we_o and mem_wdata_o unchanged until mem_ready_i. The sequence advances only on a handshake.
- R11: busy_o is 1 from the cycle after acceptance through the cycle of the last handshake, and also throughout the reset sequence. While busy_o is 1, new sources start no access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low; its release starts the reset fetch |
| instr_done_i | input | 1 | Current instruction has completed |
| addr_err_i | input | 1 | Address error pending |
| irq_i | input | 1 | Interrupt pending |
| irq_lvl_i | input | 4 | Priority level of the pending interrupt |
| irq_vec_i | input | 8 | Vector number of the pending interrupt |
| trap_i | input | 1 | Trap instruction executing |
| trap_imm_i | input | 8 | Trap immediate, used as the vector number |
| undef_i | input | 1 | Undefined opcode decoded |
| in_slot_i | input | 1 | Decoded instruction sits in a delay slot |
| slot_pc_wr_i | input | 1 | Decoded instruction rewrites the PC |
| pc_i | input | 32 | Return PC to save |
| sr_i | input | 32 | Status word to save |
| r15_i | input | 32 | Current stack pointer |
| vbr_i | input | 32 | Current vector base |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with mem_ready_i |
| mem_ready_i | input | 1 | Access completes in this cycle |
| busy_o | output | 1 | Sequence in progress |
| pc_wr_o | output | 1 | Load pc_o into PC |
| pc_o | output | 32 | New PC |
| r15_wr_o | output | 1 | Load r15_o into R15 |
| r15_o | output | 32 | New R15 |
| vbr_clr_o | output | 1 | Clear VBR |
| imask_wr_o | output | 1 | Load imask_o into the SR mask bits |
| imask_o | output | 4 | New interrupt mask |

## Verification
The bench builds the block with its default parameters: 32-bit words, 8-bit vector numbers and a 4-bit level. With these values every vector number up to 0xFF is reachable. Pairing trap immediate 0xFF with a vector base near the top of the address space checks that the table read lands on the last word without overflow. The ready input stalls one cycle in three, so each phase of the reset and push sequences meets both an immediate and a delayed handshake.

// File: rtl/exc_pkg.sv
package exc_pkg;
  typedef enum logic [2:0] {
    ST_ARM, ST_RPC, ST_RSP, ST_IDLE, ST_PSR, ST_PPC, ST_VEC
  } st_e;

  // source slots, lowest index wins
  localparam int N_SRC    = 5;
  localparam int SRC_AERR = 0;
  localparam int SRC_IRQ  = 1;
  localparam int SRC_SLOT = 2;
  localparam int SRC_ILL  = 3;
  localparam int SRC_TRAP = 4;
endpackage

// File: rtl/exc_src_arb.sv
module exc_src_arb
  import exc_pkg::*;
#(
  parameter int VEC_W    = 8,
  parameter int VEC_ILL  = 4,
  parameter int VEC_SLOT = 6,
  parameter int VEC_AERR = 9
) (
  input  logic             instr_done_i,
  input  logic             addr_err_i,
  input  logic             irq_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic             trap_i,
  input  logic [VEC_W-1:0] trap_imm_i,
  input  logic             undef_i,
  input  logic             in_slot_i,
  input  logic             slot_pc_wr_i,
  output logic             req_o,
  output logic             is_irq_o,
  output logic [VEC_W-1:0] vec_o,
  output logic [N_SRC-1:0] grant_o
);
  logic [N_SRC-1:0] cand;

  always_comb begin
    cand           = '0;
    cand[SRC_AERR] = addr_err_i & instr_done_i;
    cand[SRC_IRQ]  = irq_i & instr_done_i;
    cand[SRC_SLOT] = in_slot_i & (undef_i | slot_pc_wr_i);
    cand[SRC_ILL]  = undef_i & ~in_slot_i;
    cand[SRC_TRAP] = trap_i;
  end

  for (genvar i = 0; i < N_SRC; i++) begin : g_pri
    if (i == 0) begin : g_top
      assign grant_o[i] = cand[i];
    end else begin : g_low
      assign grant_o[i] = cand[i] & ~|cand[i-1:0];
    end
  end

  always_comb begin
    vec_o = '0;
    if (grant_o[SRC_AERR])      vec_o = VEC_W'(VEC_AERR);
    else if (grant_o[SRC_IRQ])  vec_o = irq_vec_i;
    else if (grant_o[SRC_SLOT]) vec_o = VEC_W'(VEC_SLOT);
    else if (grant_o[SRC_ILL])  vec_o = VEC_W'(VEC_ILL);
    else if (grant_o[SRC_TRAP]) vec_o = trap_imm_i;
  end

  assign req_o    = |cand;
  assign is_irq_o = grant_o[SRC_IRQ];
endmodule

// File: rtl/exc_ctrl.sv
module exc_ctrl
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          VEC_W       = 8,
  parameter int          LVL_W       = 4,
  parameter logic [31:0] RST_PC_ADDR = 32'h0000_0000,
  parameter logic [31:0] RST_SP_ADDR = 32'h0000_0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             src_req_i,
  input  logic [VEC_W-1:0] src_vec_i,
  input  logic             src_irq_i,
  input  logic [LVL_W-1:0] src_lvl_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  r15_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             pc_wr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             r15_wr_o,
  output logic [XLEN-1:0]  r15_o,
  output logic             vbr_clr_o,
  output logic             imask_wr_o,
  output logic [LVL_W-1:0] imask_o
);
  localparam int WORD_B   = XLEN / 8;
  localparam int ADDR_LSB = $clog2(WORD_B);

  st_e              st_q;
  logic [XLEN-1:0]  pc_sv, sr_sv, r15_sv, vbr_sv, pc_rst;
  logic [VEC_W-1:0] vec_sv;
  logic             irq_sv;
  logic [LVL_W-1:0] lvl_sv;
  logic             hs;

  assign hs = mem_req_o & mem_ready_i;

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = '0;
    mem_wdata_o = '0;
    unique case (st_q)
      ST_RPC: begin mem_req_o = 1'b1; mem_addr_o = XLEN'(RST_PC_ADDR); end
      ST_RSP: begin mem_req_o = 1'b1; mem_addr_o = XLEN'(RST_SP_ADDR); end
      ST_PSR: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = r15_sv - XLEN'(WORD_B);
        mem_wdata_o = sr_sv;
      end
      ST_PPC: begin
        mem_req_o   = 1'b1;
        mem_we_o    = 1'b1;
        mem_addr_o  = r15_sv - XLEN'(2 * WORD_B);
        mem_wdata_o = pc_sv;
      end
      ST_VEC: begin
        mem_req_o  = 1'b1;
        mem_addr_o = vbr_sv + (XLEN'(vec_sv) << ADDR_LSB);
      end
      default: ;
    endcase
  end

  assign busy_o = (st_q != ST_IDLE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_ARM;
      pc_sv      <= '0;
      sr_sv      <= '0;
      r15_sv     <= '0;
      vbr_sv     <= '0;
      pc_rst     <= '0;
      vec_sv     <= '0;
      irq_sv     <= 1'b0;
      lvl_sv     <= '0;
      pc_wr_o    <= 1'b0;
      pc_o       <= '0;
      r15_wr_o   <= 1'b0;
      r15_o      <= '0;
      vbr_clr_o  <= 1'b0;
      imask_wr_o <= 1'b0;
      imask_o    <= '0;
    end else begin
      pc_wr_o    <= 1'b0;
      r15_wr_o   <= 1'b0;
      vbr_clr_o  <= 1'b0;
      imask_wr_o <= 1'b0;
      unique case (st_q)
        ST_ARM: st_q <= ST_RPC;
        ST_RPC: if (hs) begin
          pc_rst <= mem_rdata_i;
          st_q   <= ST_RSP;
        end
        ST_RSP: if (hs) begin
          r15_o      <= mem_rdata_i;
          r15_wr_o   <= 1'b1;
          pc_o       <= pc_rst;
          pc_wr_o    <= 1'b1;
          vbr_clr_o  <= 1'b1;
          imask_o    <= '1;
          imask_wr_o <= 1'b1;
          st_q       <= ST_IDLE;
        end
        ST_IDLE: if (src_req_i) begin
          pc_sv  <= pc_i;
          sr_sv  <= sr_i;
          r15_sv <= r15_i;
          vbr_sv <= vbr_i;
          vec_sv <= src_vec_i;
          irq_sv <= src_irq_i;
          lvl_sv <= src_lvl_i;
          st_q   <= ST_PSR;
        end
        ST_PSR: if (hs) st_q <= ST_PPC;
        ST_PPC: if (hs) begin
          r15_o    <= r15_sv - XLEN'(2 * WORD_B);
          r15_wr_o <= 1'b1;
          st_q     <= ST_VEC;
        end
        ST_VEC: if (hs) begin
          pc_o    <= mem_rdata_i;
          pc_wr_o <= 1'b1;
          if (irq_sv) begin
            imask_o    <= lvl_sv;
            imask_wr_o <= 1'b1;
          end
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  a_r10_hold_until_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_ready_i |=> mem_req_o && $stable(mem_addr_o) &&
                                  $stable(mem_we_o) && $stable(mem_wdata_o));
  a_r4_pc_after_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |-> $past(mem_req_o && mem_ready_i && !mem_we_o));
  a_r6_imask_with_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    imask_wr_o |-> pc_wr_o);
  a_r3_r15_after_push: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r15_wr_o && !vbr_clr_o |-> $past(mem_req_o && mem_we_o && mem_ready_i));
  a_r11_busy_ends_on_pc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_wr_o |-> !busy_o);
endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_pkg::*;
#(
  parameter int          XLEN        = 32,
  parameter int          VEC_W       = 8,
  parameter int          LVL_W       = 4,
  parameter int          VEC_ILL     = 4,
  parameter int          VEC_SLOT    = 6,
  parameter int          VEC_AERR    = 9,
  parameter logic [31:0] RST_PC_ADDR = 32'h0000_0000,
  parameter logic [31:0] RST_SP_ADDR = 32'h0000_0004
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             instr_done_i,
  input  logic             addr_err_i,
  input  logic             irq_i,
  input  logic [LVL_W-1:0] irq_lvl_i,
  input  logic [VEC_W-1:0] irq_vec_i,
  input  logic             trap_i,
  input  logic [VEC_W-1:0] trap_imm_i,
  input  logic             undef_i,
  input  logic             in_slot_i,
  input  logic             slot_pc_wr_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  sr_i,
  input  logic [XLEN-1:0]  r15_i,
  input  logic [XLEN-1:0]  vbr_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [XLEN-1:0]  mem_addr_o,
  output logic [XLEN-1:0]  mem_wdata_o,
  input  logic [XLEN-1:0]  mem_rdata_i,
  input  logic             mem_ready_i,
  output logic             busy_o,
  output logic             pc_wr_o,
  output logic [XLEN-1:0]  pc_o,
  output logic             r15_wr_o,
  output logic [XLEN-1:0]  r15_o,
  output logic             vbr_clr_o,
  output logic             imask_wr_o,
  output logic [LVL_W-1:0] imask_o
);
  logic             src_req, src_irq;
  logic [VEC_W-1:0] src_vec;
  logic [N_SRC-1:0] grant;

  exc_src_arb #(
    .VEC_W(VEC_W), .VEC_ILL(VEC_ILL), .VEC_SLOT(VEC_SLOT), .VEC_AERR(VEC_AERR)
  ) u_arb (
    .instr_done_i (instr_done_i),
    .addr_err_i   (addr_err_i),
    .irq_i        (irq_i),
    .irq_vec_i    (irq_vec_i),
    .trap_i       (trap_i),
    .trap_imm_i   (trap_imm_i),
    .undef_i      (undef_i),
    .in_slot_i    (in_slot_i),
    .slot_pc_wr_i (slot_pc_wr_i),
    .req_o        (src_req),
    .is_irq_o     (src_irq),
    .vec_o        (src_vec),
    .grant_o      (grant)
  );

  exc_ctrl #(
    .XLEN(XLEN), .VEC_W(VEC_W), .LVL_W(LVL_W),
    .RST_PC_ADDR(RST_PC_ADDR), .RST_SP_ADDR(RST_SP_ADDR)
  ) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .src_req_i   (src_req),
    .src_vec_i   (src_vec),
    .src_irq_i   (src_irq),
    .src_lvl_i   (irq_lvl_i),
    .pc_i        (pc_i),
    .sr_i        (sr_i),
    .r15_i       (r15_i),
    .vbr_i       (vbr_i),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ready_i (mem_ready_i),
    .busy_o      (busy_o),
    .pc_wr_o     (pc_wr_o),
    .pc_o        (pc_o),
    .r15_wr_o    (r15_wr_o),
    .r15_o       (r15_o),
    .vbr_clr_o   (vbr_clr_o),
    .imask_wr_o  (imask_wr_o),
    .imask_o     (imask_o)
  );

  a_r8_single_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  a_r7_gated_by_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grant[SRC_AERR] || grant[SRC_IRQ]) |-> instr_done_i);
endmodule

// File: tb/exc_entry_seq_tb_top.sv
module exc_entry_seq_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        instr_done = 0, addr_err = 0, irq = 0, trap = 0;
  logic        undef = 0, in_slot = 0, slot_pcw = 0;
  logic [3:0]  irq_lvl = 0;
  logic [7:0]  irq_vec = 0, trap_imm = 0;
  logic [31:0] pc_v = 0, sr_v = 0, r15_v = 0, vbr_v = 0;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        busy, pc_wr, r15_wr, vbr_clr, imask_wr;
  logic [31:0] pc_o, r15_o;
  logic [3:0]  imask_o;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  function automatic logic [31:0] rd(logic [31:0] a);
    return {a[15:0], ~a[31:16]} ^ 32'h1357_9BDF;
  endfunction
  assign mem_rdata = rd(mem_addr);

  exc_entry_seq dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .instr_done_i(instr_done),
    .addr_err_i(addr_err), .irq_i(irq), .irq_lvl_i(irq_lvl), .irq_vec_i(irq_vec),
    .trap_i(trap), .trap_imm_i(trap_imm), .undef_i(undef), .in_slot_i(in_slot),
    .slot_pc_wr_i(slot_pcw), .pc_i(pc_v), .sr_i(sr_v), .r15_i(r15_v), .vbr_i(vbr_v),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
    .busy_o(busy), .pc_wr_o(pc_wr), .pc_o(pc_o), .r15_wr_o(r15_wr), .r15_o(r15_o),
    .vbr_clr_o(vbr_clr), .imask_wr_o(imask_wr), .imask_o(imask_o)
  );

  typedef struct {
    logic [31:0] addr;
    logic [31:0] wdata;
    bit          we;
    bit          e_r15;
    logic [31:0] r15v;
    bit          e_pc;
    bit          e_rst;
    bit          e_im;
    logic [3:0]  imv;
    string       tag;
  } item_t;
  item_t q[$];

  // expectations for the cycle after a handshake
  bit          n_pc, n_r15, n_vbr, n_im, n_rst;
  logic [31:0] n_pcv, n_r15v;
  logic [3:0]  n_imv;
  bit          hold_v;
  logic [31:0] hold_addr;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
    end
  endtask

  function automatic item_t mk(logic [31:0] a, logic [31:0] d, bit we, string tag);
    item_t it;
    it.addr = a; it.wdata = d; it.we = we; it.e_r15 = 0; it.r15v = 0;
    it.e_pc = 0; it.e_rst = 0; it.e_im = 0; it.imv = 0; it.tag = tag;
    return it;
  endfunction

  task automatic clear_next();
    n_pc = 0; n_r15 = 0; n_vbr = 0; n_im = 0; n_rst = 0;
    n_pcv = 0; n_r15v = 0; n_imv = 0;
  endtask

  task automatic push_reset();
    item_t it;
    q.push_back(mk(32'h0, 32'h0, 0, "R1"));
    it = mk(32'h4, 32'h0, 0, "R1");
    it.e_rst = 1;
    q.push_back(it);
  endtask

  task automatic push_exc(input logic [7:0] vec, input bit isirq,
                          input logic [3:0] lvl, input string tag);
    item_t it;
    q.push_back(mk(r15_v - 32'd4, sr_v, 1, "R3"));
    it = mk(r15_v - 32'd8, pc_v, 1, "R3");
    it.e_r15 = 1; it.r15v = r15_v - 32'd8;
    q.push_back(it);
    it = mk(vbr_v + {22'd0, vec, 2'b00}, 32'h0, 0, tag);
    it.e_pc = 1; it.e_im = isirq; it.imv = lvl;
    q.push_back(it);
  endtask

  // per-clock comparison against the behavioural model
  always @(negedge clk_i) begin
    item_t it;
    if (!rst_ni) begin
      chk(!mem_req, "R1", "req in reset", {31'd0, mem_req}, 0);
      hold_v = 0;
    end else begin
      chk(pc_wr == n_pc, n_rst ? "R2" : "R4", "pc_wr", {31'd0, pc_wr}, {31'd0, n_pc});
      if (n_pc) chk(pc_o == n_pcv, n_rst ? "R2" : "R4", "pc_o", pc_o, n_pcv);
      chk(r15_wr == n_r15, n_rst ? "R2" : "R3", "r15_wr", {31'd0, r15_wr}, {31'd0, n_r15});
      if (n_r15) chk(r15_o == n_r15v, n_rst ? "R2" : "R3", "r15_o", r15_o, n_r15v);
      chk(vbr_clr == n_vbr, "R2", "vbr_clr", {31'd0, vbr_clr}, {31'd0, n_vbr});
      chk(imask_wr == n_im, n_rst ? "R2" : "R6", "imask_wr", {31'd0, imask_wr}, {31'd0, n_im});
      if (n_im) chk(imask_o == n_imv, n_rst ? "R2" : "R6", "imask_o", {28'd0, imask_o}, {28'd0, n_imv});
      chk(busy == (q.size() > 0), "R11", "busy", {31'd0, busy}, {31'd0, q.size() > 0});
      if (hold_v) chk(mem_req && mem_addr == hold_addr, "R10", "held request", mem_addr, hold_addr);
      hold_v = mem_req && !mem_ready;
      hold_addr = mem_addr;
      clear_next();
      if (mem_req && mem_ready) begin
        if (q.size() == 0) begin
          chk(0, "R11", "unexpected access", mem_addr, 0);
        end else begin
          it = q.pop_front();
          chk(mem_addr == it.addr, it.tag, "addr", mem_addr, it.addr);
          chk(mem_we == it.we, it.tag, "we", {31'd0, mem_we}, {31'd0, it.we});
          if (it.we) chk(mem_wdata == it.wdata, it.tag, "wdata", mem_wdata, it.wdata);
          if (it.e_r15) begin n_r15 = 1; n_r15v = it.r15v; end
          if (it.e_pc) begin
            n_pc = 1; n_pcv = rd(it.addr); n_im = it.e_im; n_imv = it.imv;
          end
          if (it.e_rst) begin
            n_rst = 1; n_pc = 1; n_pcv = rd(32'h0); n_r15 = 1; n_r15v = rd(32'h4);
            n_vbr = 1; n_im = 1; n_imv = 4'hF;
          end
        end
      end
    end
  end

  initial begin
    int rcnt = 0;
    mem_ready = 0;
    forever begin
      @(posedge clk_i); #2;
      rcnt++;
      mem_ready = (rcnt % 3) != 0;
    end
  end

  task automatic clr_src();
    instr_done = 0; addr_err = 0; irq = 0; trap = 0;
    undef = 0; in_slot = 0; slot_pcw = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk_i);
    while (busy) @(negedge clk_i);
  endtask

  task automatic fire(input bit d, ae, ir, input logic [3:0] lvl, input logic [7:0] iv,
                      input bit tr, input logic [7:0] ti, input bit un, sl, pw,
                      input bit acc, input logic [7:0] ev, input bit eirq, input string tag);
    wait_idle();
    @(posedge clk_i); #2;
    instr_done = d; addr_err = ae; irq = ir; irq_lvl = lvl; irq_vec = iv;
    trap = tr; trap_imm = ti; undef = un; in_slot = sl; slot_pcw = pw;
    @(posedge clk_i); #2;
    clr_src();
    if (acc) push_exc(ev, eirq, lvl, tag);
    else begin
      repeat (6) @(posedge clk_i);
      @(negedge clk_i); #1;
      chk(!busy, tag, "ignored source started sequence", {31'd0, busy}, 0);
    end
  endtask

  task automatic set_ctx(input logic [31:0] p, s, r, v);
    pc_v = p; sr_v = s; r15_v = r; vbr_v = v;
  endtask

  initial begin
    clear_next();
    hold_v = 0;
    repeat (3) @(posedge clk_i);
    @(negedge clk_i); #1;
    chk(!mem_req, "R1", "reset idle", {31'd0, mem_req}, 0);
    @(posedge clk_i); #2;
    rst_ni = 1;
    push_reset();

    // R5 trap immediate vector, R3 push, R4 table read
    set_ctx(32'h0000_1234, 32'h0000_00F0, 32'h0000_2000, 32'h8000_0000);
    fire(0, 0, 0, 4'd0, 8'd0, 1, 8'h21, 0, 0, 0, 1, 8'h21, 0, "R5");
    // R5 top trap vector at top of address space
    set_ctx(32'hABCD_0010, 32'h0000_0003, 32'h0001_0000, 32'hFFFF_FC00);
    fire(0, 0, 0, 4'd0, 8'd0, 1, 8'hFF, 0, 0, 0, 1, 8'hFF, 0, "R4");
    // R9 general illegal -> 4
    set_ctx(32'h0000_5000, 32'h0000_0011, 32'h0000_3000, 32'h0000_0400);
    fire(0, 0, 0, 4'd0, 8'd0, 0, 8'd0, 1, 0, 0, 1, 8'd4, 0, "R9");
    // R9 undefined in slot -> 6
    fire(0, 0, 0, 4'd0, 8'd0, 0, 8'd0, 1, 1, 0, 1, 8'd6, 0, "R9");
    // R9 PC write in slot -> 6
    fire(0, 0, 0, 4'd0, 8'd0, 0, 8'd0, 0, 1, 1, 1, 8'd6, 0, "R9");
    // R9 PC write outside slot -> nothing
    fire(0, 0, 0, 4'd0, 8'd0, 0, 8'd0, 0, 0, 1, 0, 8'd0, 0, "R9");
    // R6 interrupt level into mask
    set_ctx(32'h0000_7770, 32'h0000_00F0, 32'h0000_4000, 32'h0000_1000);
    fire(1, 0, 1, 4'd5, 8'h40, 0, 8'd0, 0, 0, 0, 1, 8'h40, 1, "R6");
    // R7 interrupt and address error need instr_done
    fire(0, 0, 1, 4'd3, 8'h41, 0, 8'd0, 0, 0, 0, 0, 8'd0, 0, "R7");
    fire(0, 1, 0, 4'd0, 8'd0, 0, 8'd0, 0, 0, 0, 0, 8'd0, 0, "R7");
    // R5 address error -> 9
    fire(1, 1, 0, 4'd0, 8'd0, 0, 8'd0, 0, 0, 0, 1, 8'd9, 0, "R5");
    // R8 precedence
    fire(1, 1, 1, 4'd7, 8'h50, 1, 8'h22, 1, 0, 0, 1, 8'd9, 0, "R8");
    fire(1, 0, 1, 4'd2, 8'h51, 1, 8'h23, 1, 1, 0, 1, 8'h51, 1, "R8");
    fire(0, 1, 1, 4'd2, 8'h52, 1, 8'h24, 1, 1, 0, 1, 8'd6, 0, "R8");
    fire(1, 0, 0, 4'd0, 8'd0, 1, 8'h25, 1, 0, 0, 1, 8'd4, 0, "R8");

    // R11 source while busy is ignored
    set_ctx(32'h0000_9990, 32'h0000_0001, 32'h0000_6000, 32'h0000_2000);
    fire(0, 0, 0, 4'd0, 8'd0, 1, 8'h30, 0, 0, 0, 1, 8'h30, 0, "R11");
    @(posedge clk_i); #2;
    instr_done = 1; irq = 1; irq_lvl = 4'd9; irq_vec = 8'h60; trap = 1; trap_imm = 8'h31;
    @(posedge clk_i); #2;
    clr_src();
    wait_idle();
    repeat (4) @(negedge clk_i);
    #1 chk(!busy && q.size() == 0, "R11", "late source after busy", {31'd0, busy}, 0);

    // R1 reset during a sequence restarts the reset fetch
    set_ctx(32'h0000_AAA0, 32'h0000_0002, 32'h0000_7000, 32'h0000_3000);
    fire(0, 0, 0, 4'd0, 8'd0, 1, 8'h10, 0, 0, 0, 1, 8'h10, 0, "R1");
    repeat (2) @(posedge clk_i);
    #2 rst_ni = 0;
    q.delete();
    clear_next();
    repeat (3) @(posedge clk_i);
    #2 rst_ni = 1;
    push_reset();
    wait_idle();
    repeat (3) @(negedge clk_i);
    #1 chk(q.size() == 0, "R2", "reset sequence drained", q.size(), 0);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule